// File: doc/BRIEF.md
# Full-Duplex Asynchronous Serial Transceiver

This block is a two-wire asynchronous serial port. The transmit path and the receive path are independent, so a frame can be sent and another received at the same time. Each frame is a low start bit, then 7, 8 or 9 data bits sent least significant bit first, then a high stop bit. There is no parity bit. The bit period is a programmable number of base-clock ticks, from 16 to 8192. The base clock runs at three times the instruction rate, so the bit period spans 16/3 to 8192/3 instruction cycles.

The host loads a data word and pulses a start strobe. While a frame is in flight, one more word may be queued in a holding slot. The transmitter then sends it straight after the current frame, with a second stop bit between the two frames. The receiver passes the line through two synchroniser flops and finds the falling start edge. It checks the start bit again at mid-bit and samples every following bit at mid-bit. It then presents the word with a done flag, a framing-error flag and an overrun flag. The done and overrun flags stay set until the host pulses a read strobe.

Top module: `uart_duplex`

## Requirements
- R1: After synchronous reset, `txd_o` is 1 and `tx_busy_o`, `tx_hold_o`, `tx_done_o`, `rx_done_o`, `rx_ferr_o` and `rx_ovr_o` are all 0.
- R2: A start strobe taken while the transmitter is idle drives `txd_o` low and `tx_busy_o` high from the next clock. The line stays low for one bit period and then carries the data bits, least significant bit first, one bit period each.
- R3: `len_sel_i` selects the frame length: code 0 gives 7 data bits, code 1 gives 8, code 2 gives 9 and code 3 gives 8. Received data bits above the selected length read as 0.
- R4: A frame with nothing queued behind it ends with one high stop bit. `tx_done_o` then pulses for exactly one clock, in the same cycle that `tx_busy_o` falls.
- R5: A start strobe taken while busy, with the holding slot empty, is queued and raises `tx_hold_o`. After the current frame the queued word follows with two stop bits between the frames, so the two start edges are div*(n+3) clocks apart. Only one `tx_done_o` pulse is given, after the last frame.
- R6: One bit period lasts exactly `div_i` clocks, for any value of `div_i` from 16 to 8192.
- R7: The transmit and receive paths run at the same time without affecting each other.
- R8: The receiver samples each bit at mid-bit. When the stop bit is sampled it presents the word on `rx_data_o` and sets `rx_done_o`.
- R9: A low pulse on `rxd_i` that is high again by the middle of the start bit produces no word and leaves `rx_done_o` at 0.
- R10: A low stop-bit sample sets `rx_ferr_o`, and the word is still delivered. A high stop-bit sample clears `rx_ferr_o`.
- R11: `rx_done_o` stays set until `rx_rd_i` is pulsed. A read strobe clears `rx_done_o` and `rx_ovr_o` on the next clock.
- R12: A word that completes while `rx_done_o` is still set raises `rx_ovr_o`, and `rx_data_o` takes the newer word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, three ticks per instruction cycle |
| rst | input | 1 | Synchronous active-high reset |
| div_i | input | 14 | Bit period in clock ticks (16 to 8192) |
| len_sel_i | input | 2 | Data-length code |
| tx_data_i | input | 9 | Word to transmit |
| tx_start_i | input | 1 | Transmit start strobe |
| tx_busy_o | output | 1 | A frame is being sent |
| tx_hold_o | output | 1 | A queued word is waiting |
| tx_done_o | output | 1 | One-clock pulse when the transmitter goes idle |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line |
| rx_rd_i | input | 1 | Read strobe for the received word |
| rx_data_o | output | 9 | Last received word |
| rx_done_o | output | 1 | A received word is waiting |
| rx_ferr_o | output | 1 | Stop bit of the last word was low |
| rx_ovr_o | output | 1 | A word was overwritten before it was read |

## Verification
The transmit line and the busy flag respond one clock after an accepted start strobe. The bench checks both at the first falling clock edge after that strobe. It decodes the transmitted bits at the middle of each bit period, counted from the falling edge it saw on the line. For a queued word it compares the spacing of the two start edges, in clocks, against div*(n+3). A received word appears about three clocks after its stop-bit mid-point, so the bench reads `rx_data_o` and the flags only after it has driven the whole stop bit. The read strobe clears the flags after one clock, and the bench checks them one clock after the strobe.

// File: rtl/uart_duplex_pkg.sv
package uart_duplex_pkg;

    typedef enum logic [1:0] {
        LEN_7  = 2'd0,
        LEN_8  = 2'd1,
        LEN_9  = 2'd2,
        LEN_8B = 2'd3
    } len_e;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_STOP1, TX_STOP2
    } tx_st_e;

    typedef enum logic [1:0] {
        RX_IDLE, RX_START, RX_DATA, RX_STOP
    } rx_st_e;

    typedef struct packed {
        logic [8:0] data;
        logic       ferr;
    } rx_word_t;

    function automatic logic [3:0] len_bits(input logic [1:0] code);
        case (len_e'(code))
            LEN_7:   return 4'd7;
            LEN_9:   return 4'd9;
            default: return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/uart_tx_path.sv
module uart_tx_path
    import uart_duplex_pkg::*;
#(
    parameter int DIV_W = 14,
    parameter int DW    = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    input  logic [1:0]       len_sel_i,
    input  logic [DW-1:0]    tx_data_i,
    input  logic             tx_start_i,
    output logic             tx_busy_o,
    output logic             tx_hold_o,
    output logic             tx_done_o,
    output logic             txd_o
);
    tx_st_e           st_q;
    logic [DIV_W-1:0] cnt_q;
    logic [3:0]       bit_q, nbits_q;
    logic [DW-1:0]    sh_q, pend_q;
    logic             pend_v_q, txd_q, done_q;
    logic             cell_end, take_q;

    assign cell_end = (cnt_q == div_i - 1'b1);
    assign take_q   = (st_q != TX_IDLE) && !pend_v_q && tx_start_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= TX_IDLE;
            cnt_q    <= '0;
            bit_q    <= '0;
            nbits_q  <= 4'd8;
            sh_q     <= '0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
            txd_q    <= 1'b1;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (take_q) begin
                pend_v_q <= 1'b1;
                pend_q   <= tx_data_i;
            end
            if (st_q == TX_IDLE) begin
                cnt_q <= '0;
                if (tx_start_i) begin
                    st_q    <= TX_START;
                    sh_q    <= tx_data_i;
                    nbits_q <= len_bits(len_sel_i);
                    txd_q   <= 1'b0;
                end
            end else if (!cell_end) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
                case (st_q)
                    TX_START: begin
                        st_q  <= TX_DATA;
                        bit_q <= '0;
                        txd_q <= sh_q[0];
                    end
                    TX_DATA: begin
                        if (bit_q == nbits_q - 1'b1) begin
                            st_q  <= TX_STOP1;
                            txd_q <= 1'b1;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                            sh_q  <= sh_q >> 1;
                            txd_q <= sh_q[1];
                        end
                    end
                    TX_STOP1: begin
                        if (pend_v_q || tx_start_i) begin
                            st_q <= TX_STOP2;
                        end else begin
                            st_q   <= TX_IDLE;
                            done_q <= 1'b1;
                        end
                    end
                    TX_STOP2: begin
                        st_q     <= TX_START;
                        sh_q     <= pend_q;
                        pend_v_q <= 1'b0;
                        nbits_q  <= len_bits(len_sel_i);
                        txd_q    <= 1'b0;
                    end
                    default: st_q <= TX_IDLE;
                endcase
            end
        end
    end

    assign tx_busy_o = (st_q != TX_IDLE);
    assign tx_hold_o = pend_v_q;
    assign tx_done_o = done_q;
    assign txd_o     = txd_q;

    AST_TX_IDLE_MARK: assert property (@(posedge clk) disable iff (rst)
        !tx_busy_o |-> txd_o);                                   // R4
    AST_TX_START_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_busy_o) |-> !txd_o);                            // R2
    AST_TX_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        tx_done_o |=> !tx_done_o);                               // R4
    AST_TX_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        tx_done_o |-> !tx_busy_o && !tx_hold_o);                 // R4
    AST_TX_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
        tx_hold_o |-> tx_busy_o);                                // R5
endmodule

// File: rtl/uart_rx_path.sv
module uart_rx_path
    import uart_duplex_pkg::*;
#(
    parameter int DIV_W = 14,
    parameter int DW    = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    input  logic [1:0]       len_sel_i,
    input  logic             rxd_i,
    input  logic             rx_rd_i,
    output logic [DW-1:0]    rx_data_o,
    output logic             rx_done_o,
    output logic             rx_ferr_o,
    output logic             rx_ovr_o
);
    rx_st_e           st_q;
    logic             s1_q, s2_q, prev_q;
    logic [DIV_W-1:0] cnt_q;
    logic [3:0]       bit_q, nbits_q;
    logic [DW-1:0]    acc_q;
    rx_word_t         word_q;
    logic             done_q, ovr_q;
    logic             cell_end, half_end, finish;

    assign cell_end = (cnt_q == div_i - 1'b1);
    assign half_end = (cnt_q == (div_i >> 1) - 1'b1);
    assign finish   = (st_q == RX_STOP) && cell_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q    <= 1'b1;
            s2_q    <= 1'b1;
            prev_q  <= 1'b1;
            st_q    <= RX_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            nbits_q <= 4'd8;
            acc_q   <= '0;
            word_q  <= '0;
            done_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            s1_q   <= rxd_i;
            s2_q   <= s1_q;
            prev_q <= s2_q;
            if (rx_rd_i) begin
                done_q <= 1'b0;
                ovr_q  <= 1'b0;
            end
            case (st_q)
                RX_IDLE: begin
                    cnt_q <= '0;
                    if (prev_q && !s2_q) begin
                        st_q    <= RX_START;
                        acc_q   <= '0;
                        nbits_q <= len_bits(len_sel_i);
                    end
                end
                RX_START: begin
                    if (half_end) begin
                        cnt_q <= '0;
                        bit_q <= '0;
                        st_q  <= s2_q ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cell_end) begin
                        cnt_q        <= '0;
                        acc_q[bit_q] <= s2_q;
                        if (bit_q == nbits_q - 1'b1) st_q <= RX_STOP;
                        else                         bit_q <= bit_q + 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cell_end) begin
                        cnt_q       <= '0;
                        st_q        <= RX_IDLE;
                        word_q.data <= acc_q;
                        word_q.ferr <= !s2_q;
                        done_q      <= 1'b1;
                        ovr_q       <= (done_q || ovr_q) && !rx_rd_i;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: st_q <= RX_IDLE;
            endcase
        end
    end

    assign rx_data_o = word_q.data;
    assign rx_ferr_o = word_q.ferr;
    assign rx_done_o = done_q;
    assign rx_ovr_o  = ovr_q;

    AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        rx_rd_i && !finish |=> !rx_done_o && !rx_ovr_o);         // R11
    AST_RX_OVR_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ovr_o) |-> $past(rx_done_o));                   // R12
    AST_RX_FINISH_SETS_DONE: assert property (@(posedge clk) disable iff (rst)
        finish |=> rx_done_o);                                   // R8
    AST_RX_OVR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        rx_ovr_o |-> rx_done_o);                                 // R12
endmodule

// File: rtl/uart_duplex.sv
module uart_duplex
    import uart_duplex_pkg::*;
#(
    parameter int DIV_W = 14,
    parameter int DW    = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    input  logic [1:0]       len_sel_i,
    input  logic [DW-1:0]    tx_data_i,
    input  logic             tx_start_i,
    output logic             tx_busy_o,
    output logic             tx_hold_o,
    output logic             tx_done_o,
    output logic             txd_o,
    input  logic             rxd_i,
    input  logic             rx_rd_i,
    output logic [DW-1:0]    rx_data_o,
    output logic             rx_done_o,
    output logic             rx_ferr_o,
    output logic             rx_ovr_o
);
    uart_tx_path #(.DIV_W(DIV_W), .DW(DW)) u_tx (
        .clk(clk), .rst(rst), .div_i(div_i), .len_sel_i(len_sel_i),
        .tx_data_i(tx_data_i), .tx_start_i(tx_start_i),
        .tx_busy_o(tx_busy_o), .tx_hold_o(tx_hold_o),
        .tx_done_o(tx_done_o), .txd_o(txd_o)
    );

    uart_rx_path #(.DIV_W(DIV_W), .DW(DW)) u_rx (
        .clk(clk), .rst(rst), .div_i(div_i), .len_sel_i(len_sel_i),
        .rxd_i(rxd_i), .rx_rd_i(rx_rd_i), .rx_data_o(rx_data_o),
        .rx_done_o(rx_done_o), .rx_ferr_o(rx_ferr_o), .rx_ovr_o(rx_ovr_o)
    );
endmodule

// File: tb/uart_duplex_bench.sv
module uart_duplex_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] div = 14'd16;
    logic [1:0]  len_sel = 2'd1;
    logic [8:0]  tx_data = '0;
    logic        tx_start = 1'b0;
    logic        rx_line = 1'b1;
    logic        rx_rd = 1'b0;
    logic        tx_busy, tx_hold, tx_done, txd;
    logic [8:0]  rx_data;
    logic        rx_done, rx_ferr, rx_ovr;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int done_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst && tx_done) done_cnt <= done_cnt + 1;
    end

    uart_duplex u_uart_duplex (
        .clk(clk), .rst(rst), .div_i(div), .len_sel_i(len_sel),
        .tx_data_i(tx_data), .tx_start_i(tx_start),
        .tx_busy_o(tx_busy), .tx_hold_o(tx_hold), .tx_done_o(tx_done),
        .txd_o(txd), .rxd_i(rx_line), .rx_rd_i(rx_rd),
        .rx_data_o(rx_data), .rx_done_o(rx_done),
        .rx_ferr_o(rx_ferr), .rx_ovr_o(rx_ovr)
    );

    function automatic int nbits_of(input logic [1:0] code);
        return (code == 2'd0) ? 7 : (code == 2'd2) ? 9 : 8;
    endfunction

    function automatic logic [8:0] masked(input logic [8:0] d, input logic [1:0] code);
        return d & 9'((1 << nbits_of(code)) - 1);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tx_kick(input logic [8:0] d);
        @(negedge clk);
        tx_data  = d;
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
    endtask

    // decode one frame from txd; returns word and the cycle of the falling edge
    task automatic tx_decode(input int n, output logic [8:0] w, output int fall, output bit stop_ok);
        w = '0;
        while (txd !== 1'b0) @(negedge clk);
        fall = cyc;
        repeat (div / 2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            repeat (div) @(negedge clk);
            w[i] = txd;
        end
        repeat (div) @(negedge clk);
        stop_ok = (txd === 1'b1);
    endtask

    task automatic rx_send(input logic [8:0] d, input int n, input logic stopv);
        @(negedge clk);
        rx_line = 1'b0;
        repeat (div) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            rx_line = d[i];
            repeat (div) @(negedge clk);
        end
        rx_line = stopv;
        repeat (div) @(negedge clk);
        rx_line = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic rx_read();
        @(negedge clk);
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog R2 actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic [8:0] w, w2, d1, d2;
        int f1, f2, dc;
        bit sok, sok2;
        void'($urandom(32'd1913));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(txd === 1'b1, "R1 txd", int'(txd), 1);
        chk(!tx_busy && !tx_hold && !tx_done, "R1 tx flags", int'({tx_busy, tx_hold, tx_done}), 0);
        chk(!rx_done && !rx_ferr && !rx_ovr, "R1 rx flags", int'({rx_done, rx_ferr, rx_ovr}), 0);

        // R2 start latency
        div = 14'd16; len_sel = 2'd1;
        @(negedge clk); tx_data = 9'h0A5; tx_start = 1'b1;
        @(negedge clk); tx_start = 1'b0;
        chk(txd === 1'b0 && tx_busy === 1'b1, "R2 start latency", int'({tx_busy, txd}), 2);
        repeat (12 * 16) @(negedge clk);
        chk(!tx_busy, "R4 idle after frame", int'(tx_busy), 0);

        // random full-duplex frames: R2 R3 R6 R7 R8 R4
        for (int k = 0; k < 24; k++) begin
            div     = 14'(16 + ($urandom % 25));
            len_sel = 2'($urandom % 4);
            d1 = 9'($urandom); d2 = 9'($urandom);
            dc = done_cnt;
            fork
                begin
                    tx_kick(d1);
                    tx_decode(nbits_of(len_sel), w, f1, sok);
                    chk(w == masked(d1, len_sel), "R2 R3 R7 tx data", int'(w), int'(masked(d1, len_sel)));
                    chk(sok, "R4 stop bit", int'(sok), 1);
                    repeat (div) @(negedge clk);
                    chk(done_cnt == dc + 1 && !tx_busy, "R4 done pulse", done_cnt - dc, 1);
                end
                begin
                    rx_send(d2, nbits_of(len_sel), 1'b1);
                    chk(rx_done === 1'b1, "R8 R7 rx done", int'(rx_done), 1);
                    chk(rx_data == masked(d2, len_sel), "R8 R3 rx data", int'(rx_data), int'(masked(d2, len_sel)));
                    chk(!rx_ferr && !rx_ovr, "R10 R12 clean flags", int'({rx_ferr, rx_ovr}), 0);
                    rx_read();
                    chk(!rx_done, "R11 read clears", int'(rx_done), 0);
                end
            join
        end

        // R6 exact bit period via frame spacing, and R5 back-to-back with two stops
        div = 14'd20; len_sel = 2'd1;
        dc = done_cnt;
        fork
            begin
                tx_kick(9'h13C);
                repeat (30) @(negedge clk);
                tx_kick(9'h0C3);
                chk(tx_hold === 1'b1, "R5 hold set", int'(tx_hold), 1);
            end
            begin
                tx_decode(8, w, f1, sok);
                tx_decode(8, w2, f2, sok2);
                chk(w == 9'h03C && w2 == 9'h0C3, "R5 words", int'({w, w2}), int'({9'h03C, 9'h0C3}));
                chk(f2 - f1 == 20 * 11, "R5 R6 two stop bits", f2 - f1, 220);
                repeat (div) @(negedge clk);
                chk(done_cnt == dc + 1 && !tx_busy, "R5 single done", done_cnt - dc, 1);
            end
        join

        // R6 large divisor bit period
        div = 14'd1000; len_sel = 2'd0;
        fork
            tx_kick(9'h055);
            begin
                tx_decode(7, w, f1, sok);
                chk(w == 9'h055 && sok, "R6 div 1000 frame", int'(w), 9'h055);
            end
        join

        // R9 glitch
        div = 14'd24; len_sel = 2'd1;
        @(negedge clk); rx_line = 1'b0;
        repeat (3) @(negedge clk); rx_line = 1'b1;
        repeat (24 * 12) @(negedge clk);
        chk(!rx_done, "R9 glitch ignored", int'(rx_done), 0);

        // R10 framing error, word kept
        rx_send(9'h09A, 8, 1'b0);
        chk(rx_ferr === 1'b1 && rx_done === 1'b1, "R10 ferr set", int'({rx_ferr, rx_done}), 3);
        chk(rx_data == 9'h09A, "R10 data kept", int'(rx_data), 9'h09A);
        rx_read();

        // R12 overrun, R11 done held until read
        len_sel = 2'd2;
        rx_send(9'h1F0, 9, 1'b1);
        chk(!rx_ferr, "R10 ferr cleared", int'(rx_ferr), 0);
        repeat (50) @(negedge clk);
        chk(rx_done === 1'b1 && !rx_ovr, "R11 done held", int'({rx_done, rx_ovr}), 2);
        rx_send(9'h10F, 9, 1'b1);
        chk(rx_ovr === 1'b1, "R12 overrun", int'(rx_ovr), 1);
        chk(rx_data == 9'h10F, "R12 newer word", int'(rx_data), 9'h10F);
        rx_read();
        chk(!rx_done && !rx_ovr, "R11 read clears both", int'({rx_done, rx_ovr}), 0);

        // R3 code 3 is eight bits
        len_sel = 2'd3;
        rx_send(9'h1FF, 9, 1'b1);
        chk(rx_data == 9'h0FF, "R3 code3 eight bits", int'(rx_data), 9'h0FF);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule